// File: doc/BRIEF.md
# Page-Written Flag Tracker

This block records which physical memory pages have been written by user-mode software. Memory is viewed as 16 half blocks of 8 pages each, 128 pages in all, and the block keeps one sticky flag per page. A write strobe that carries a physical page number and a user-mode qualifier sets the flag for that page. Writes made in supervisor mode leave the flags alone. A synchronous clear input wipes every flag.

Supervisor software inspects the flags a pair of half blocks at a time. A select command loads a 4-bit half-block pointer. Each accepted read returns one 16-bit word that holds the flags of the pointed half block and of the half block after it. A read then moves the pointer on. A plain read steps it by one half block, so the next read overlaps the previous one by eight flags. A read with the advance option steps it by two, so a chain of such reads sweeps consecutive blocks with no overlap. Because the pointer wraps modulo 16, half block 15 pairs with half block 0.

Read commands and read results form a valid/ready stream through a single output register. A read is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high while the output register is empty or is being drained in the same cycle (`out_valid && out_ready`). Once `out_valid` is high, the result word holds steady until `out_ready` takes it. A producer that raises `rd_valid` must hold it, together with `rd_adv`, until `rd_ready` is seen.

Top module: `pgwr_tracker`

## Requirements
- R1: After reset all 128 flags are 0, the pair pointer is half block 0, `out_valid` is 0 and `rd_ready` is 1.
- R2: A strobe with `wr_en=1` and `wr_user=1` sets the flag of page `wr_page`, where the half block is `wr_page[6:3]` and the page within it is `wr_page[2:0]`. The flag is visible to reads accepted from the next cycle on and stays set until a clear.
- R3: A strobe with `wr_en=1` and `wr_user=0` changes no flag.
- R4: `sel_en=1` loads `sel_hb` into the pointer at that edge. Select has priority over any pointer step from a read accepted in the same cycle, and that read still uses the old pointer. An even `sel_hb` names exactly one whole block.
- R5: A result word carries the flags of pointer half block P in bits 7:0 and the flags of half block (P+1) mod 16 in bits 15:8. Bit i of each byte is page i of its half block, and 1 means written.
- R6: An accepted read with `rd_adv=0` moves the pointer from P to (P+1) mod 16, so the following read overlaps by eight flags.
- R7: An accepted read with `rd_adv=1` moves the pointer from P to (P+2) mod 16.
- R8: The pointer wraps modulo 16, so pointer 15 pairs half block 15 (low byte) with half block 0 (high byte).
- R9: `clr=1` sets all flags to 0 at that edge. It takes priority over a user write in the same cycle.
- R10: A read is accepted when `rd_valid && rd_ready`, and `rd_ready = !out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid` stays 1 and `out_word` does not change.
- R11: The result word reflects the flags as they stood before the accepting edge, so a user write in the same cycle as the accepted read does not appear in that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all flags |
| wr_en | input | 1 | Memory write strobe |
| wr_user | input | 1 | Write was made in user mode |
| wr_page | input | 7 | Physical page number of the write |
| sel_en | input | 1 | Load the pair pointer |
| sel_hb | input | 4 | Half block to load into the pointer |
| rd_valid | input | 1 | Read command valid |
| rd_adv | input | 1 | Read steps the pointer by a full pair |
| rd_ready | output | 1 | Read command can be accepted |
| out_valid | output | 1 | Result word valid |
| out_ready | input | 1 | Consumer takes the result word |
| out_word | output | 16 | Flags of the selected pair |

## Verification
The bench walks the pointer through plain and advancing reads. An off-by-one in the step would show up as a word missing or repeating the eight overlapped flags. Reads at pointer 15 check the wrap, where a design that saturates or forgets the modulo would return the wrong high byte. Same-cycle collisions are driven on purpose: select with read, clear with write, and write with read. A wrong priority there appears as a stale pointer, a surviving flag, or a flag showing up one read early. A stalled consumer checks that the held result word never changes and that the next command waits.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  // How far an accepted read moves the pair pointer.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_PAIR = 2'd2
  } ptr_step_e;
endpackage

// File: rtl/pgwr_flag_store.sv
module pgwr_flag_store #(
  parameter int PG_PER_HB = 8,
  parameter int NUM_HB    = 16,
  localparam int PB_W     = $clog2(PG_PER_HB),
  localparam int HB_W     = $clog2(NUM_HB),
  localparam int PG_W     = PB_W + HB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic                 wr_user,
  input  logic [PG_W-1:0]      wr_page,
  input  logic [HB_W-1:0]      lo_hb,
  input  logic [HB_W-1:0]      hi_hb,
  output logic [PG_PER_HB-1:0] lo_flags,
  output logic [PG_PER_HB-1:0] hi_flags
);
  logic [NUM_HB-1:0][PG_PER_HB-1:0] flags;
  logic [HB_W-1:0] set_hb;
  logic [PB_W-1:0] set_bit;
  logic            set_en;

  assign set_hb  = wr_page[PG_W-1:PB_W];
  assign set_bit = wr_page[PB_W-1:0];
  assign set_en  = wr_en && wr_user;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (clr) begin
      flags <= '0;
    end else if (set_en) begin
      for (int h = 0; h < NUM_HB; h++) begin
        if (set_hb == HB_W'(h)) flags[h][set_bit] <= 1'b1;
      end
    end
  end

  assign lo_flags = flags[lo_hb];
  assign hi_flags = flags[hi_hb];

  // R2
  user_write_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr) |=> flags[$past(set_hb)][$past(set_bit)]);

  // R2
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  // R3
  super_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_user && !clr) |=> (flags == $past(flags)));

  // R9
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0));
endmodule

// File: rtl/pgwr_sel_ptr.sv
module pgwr_sel_ptr
  import pgwr_pkg::*;
#(
  parameter int NUM_HB = 16,
  localparam int HB_W  = $clog2(NUM_HB),
  localparam bit POW2  = (NUM_HB == (1 << HB_W))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_en,
  input  logic [HB_W-1:0] sel_hb,
  input  ptr_step_e       step,
  output logic [HB_W-1:0] ptr,
  output logic [HB_W-1:0] ptr_nx1
);
  logic [HB_W-1:0] ptr_nx2;

  generate
    if (POW2) begin : g_wrap_free
      assign ptr_nx1 = ptr + HB_W'(1);
      assign ptr_nx2 = ptr + HB_W'(2);
    end else begin : g_wrap_cmp
      always_comb begin
        ptr_nx1 = (int'(ptr) >= NUM_HB - 1) ? HB_W'(int'(ptr) + 1 - NUM_HB) : ptr + HB_W'(1);
        ptr_nx2 = (int'(ptr) >= NUM_HB - 2) ? HB_W'(int'(ptr) + 2 - NUM_HB) : ptr + HB_W'(2);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (sel_en) begin
      ptr <= sel_hb;
    end else begin
      unique case (step)
        STEP_ONE:  ptr <= ptr_nx1;
        STEP_PAIR: ptr <= ptr_nx2;
        default:   ptr <= ptr;
      endcase
    end
  end

  // R4
  select_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_en |=> (ptr == $past(sel_hb)));

  // R8
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en && step == STEP_ONE && int'(ptr) == NUM_HB - 1) |=> (ptr == '0));

  // R6
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en && step == STEP_HOLD) |=> $stable(ptr));
endmodule

// File: rtl/pgwr_out_reg.sv
module pgwr_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_valid,
  output logic         rd_ready,
  output logic         accept,
  input  logic [W-1:0] word_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  assign rd_ready = !out_valid || out_ready;
  assign accept   = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_word  <= word_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R10
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: rtl/pgwr_tracker.sv
module pgwr_tracker
  import pgwr_pkg::*;
#(
  parameter int PG_PER_HB = 8,
  parameter int NUM_HB    = 16,
  localparam int PB_W     = $clog2(PG_PER_HB),
  localparam int HB_W     = $clog2(NUM_HB),
  localparam int PG_W     = PB_W + HB_W,
  localparam int WORD_W   = 2 * PG_PER_HB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              wr_user,
  input  logic [PG_W-1:0]   wr_page,
  input  logic              sel_en,
  input  logic [HB_W-1:0]   sel_hb,
  input  logic              rd_valid,
  input  logic              rd_adv,
  output logic              rd_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  logic [HB_W-1:0]      ptr;
  logic [HB_W-1:0]      ptr_nx1;
  logic [PG_PER_HB-1:0] lo_flags;
  logic [PG_PER_HB-1:0] hi_flags;
  logic                 accept;
  ptr_step_e            step;

  always_comb begin
    if (!accept)     step = STEP_HOLD;
    else if (rd_adv) step = STEP_PAIR;
    else             step = STEP_ONE;
  end

  pgwr_flag_store #(.PG_PER_HB(PG_PER_HB), .NUM_HB(NUM_HB)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .wr_en    (wr_en),
    .wr_user  (wr_user),
    .wr_page  (wr_page),
    .lo_hb    (ptr),
    .hi_hb    (ptr_nx1),
    .lo_flags (lo_flags),
    .hi_flags (hi_flags)
  );

  pgwr_sel_ptr #(.NUM_HB(NUM_HB)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_en  (sel_en),
    .sel_hb  (sel_hb),
    .step    (step),
    .ptr     (ptr),
    .ptr_nx1 (ptr_nx1)
  );

  pgwr_out_reg #(.W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .accept    (accept),
    .word_in   ({hi_flags, lo_flags}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word)
  );

  // R7
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_adv && !sel_en) |=> (ptr == HB_W'(($past(int'(ptr)) + 2) % NUM_HB)));

  // R5
  word_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clr && !wr_en) |=> (out_word[PG_PER_HB-1:0] == $past(lo_flags)));
endmodule

// File: tb/pgwr_tracker_bench.sv
`timescale 1ns/100ps
module pgwr_tracker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, wr_en = 1'b0, wr_user = 1'b0;
  logic [6:0] wr_page = '0;
  logic sel_en = 1'b0;
  logic [3:0] sel_hb = '0;
  logic rd_valid = 1'b0, rd_adv = 1'b0, out_ready = 1'b1;
  logic rd_ready, out_valid;
  logic [15:0] out_word;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pgwr_tracker u_pgwr_tracker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_user(wr_user),
    .wr_page(wr_page), .sel_en(sel_en), .sel_hb(sel_hb), .rd_valid(rd_valid),
    .rd_adv(rd_adv), .rd_ready(rd_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  // Vector: op[31:30] (0 write, 1 select, 2 read, 3 clear), adv[29], user[28],
  // arg[27:21], req[20:16], expected word[15:0]
  function automatic logic [31:0] mk(input logic [1:0] op, input logic adv,
      input logic user, input logic [6:0] arg, input logic [4:0] req, input logic [15:0] exp);
    return {op, adv, user, arg, req, exp};
  endfunction

  localparam int NV = 22;
  localparam logic [31:0] VEC [NV] = '{
    mk(2'd2, 1'b0, 1'b0, 7'd0,   5'd1, 16'h0000), // R1 clean flags, pointer 0
    mk(2'd0, 1'b0, 1'b1, 7'd0,   5'd2, 16'h0000), // R2 user write page 0
    mk(2'd0, 1'b0, 1'b1, 7'd9,   5'd2, 16'h0000), // R2 user write page 9
    mk(2'd0, 1'b0, 1'b0, 7'd2,   5'd3, 16'h0000), // R3 supervisor write page 2
    mk(2'd0, 1'b0, 1'b1, 7'd23,  5'd2, 16'h0000), // R2 user write page 23
    mk(2'd1, 1'b0, 1'b0, 7'd0,   5'd4, 16'h0000), // R4 select 0
    mk(2'd2, 1'b0, 1'b0, 7'd0,   5'd5, 16'h0201), // R5 R3 pair 0,1
    mk(2'd2, 1'b0, 1'b0, 7'd0,   5'd6, 16'h8002), // R6 overlap pair 1,2
    mk(2'd2, 1'b1, 1'b0, 7'd0,   5'd6, 16'h0080), // R6 pair 2,3
    mk(2'd0, 1'b0, 1'b1, 7'd127, 5'd2, 16'h0000),
    mk(2'd0, 1'b0, 1'b1, 7'd120, 5'd2, 16'h0000),
    mk(2'd0, 1'b0, 1'b1, 7'd35,  5'd2, 16'h0000),
    mk(2'd2, 1'b1, 1'b0, 7'd0,   5'd7, 16'h0008), // R7 pair 4,5
    mk(2'd1, 1'b0, 1'b0, 7'd15,  5'd4, 16'h0000),
    mk(2'd2, 1'b1, 1'b0, 7'd0,   5'd8, 16'h0181), // R8 pair 15,0
    mk(2'd2, 1'b1, 1'b0, 7'd0,   5'd8, 16'h8002), // R8 wrapped to pair 1,2
    mk(2'd1, 1'b0, 1'b0, 7'd2,   5'd4, 16'h0000),
    mk(2'd2, 1'b1, 1'b0, 7'd0,   5'd4, 16'h0080), // R4 even select = block 1
    mk(2'd3, 1'b0, 1'b0, 7'd0,   5'd9, 16'h0000),
    mk(2'd1, 1'b0, 1'b0, 7'd15,  5'd4, 16'h0000),
    mk(2'd2, 1'b0, 1'b0, 7'd0,   5'd9, 16'h0000), // R9 all cleared
    mk(2'd2, 1'b0, 1'b0, 7'd0,   5'd9, 16'h0000)  // R9 all cleared
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [6:0] pg, input logic user);
    wr_en = 1'b1; wr_user = user; wr_page = pg;
    tick();
    wr_en = 1'b0; wr_user = 1'b0;
  endtask

  task automatic do_select(input logic [3:0] hb);
    sel_en = 1'b1; sel_hb = hb;
    tick();
    sel_en = 1'b0;
  endtask

  task automatic do_read(input logic adv, input logic [15:0] exp, input string req);
    rd_valid = 1'b1; rd_adv = adv;
    tick();
    rd_valid = 1'b0; rd_adv = 1'b0;
    chk(out_valid === 1'b1 && out_word === exp, req, out_word, exp);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk(out_valid === 1'b0, "R1 out_valid", {15'd0, out_valid}, 16'h0000);
    chk(rd_ready === 1'b1, "R1 rd_ready", {15'd0, rd_ready}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d vec %0d", v[20:16], i);
      case (v[31:30])
        2'd0: do_write(v[27:21], v[28]);
        2'd1: do_select(v[24:21]);
        2'd2: do_read(v[29], v[15:0], rq);
        default: begin clr = 1'b1; tick(); clr = 1'b0; end
      endcase
    end

    // R10 back-pressure: result held, next command waits
    tick();
    do_write(7'd5, 1'b1);
    do_write(7'd17, 1'b1);
    do_select(4'd0);
    out_ready = 1'b0;
    rd_valid = 1'b1; rd_adv = 1'b1;
    tick();
    rd_adv = 1'b0;
    chk(out_valid === 1'b1 && out_word === 16'h0020, "R10 first word", out_word, 16'h0020);
    chk(rd_ready === 1'b0, "R10 rd_ready low on stall", {15'd0, rd_ready}, 16'h0000);
    tick();
    tick();
    chk(out_valid === 1'b1 && out_word === 16'h0020, "R10 word held", out_word, 16'h0020);
    out_ready = 1'b1;
    tick();
    rd_valid = 1'b0;
    chk(out_valid === 1'b1 && out_word === 16'h0002, "R10 waiting read pair 2,3", out_word, 16'h0002);

    // R11 write in the same cycle as the read is not in that word
    do_select(4'd4);
    wr_en = 1'b1; wr_user = 1'b1; wr_page = 7'd33;
    rd_valid = 1'b1; rd_adv = 1'b0;
    tick();
    wr_en = 1'b0; wr_user = 1'b0; rd_valid = 1'b0;
    chk(out_word === 16'h0000, "R11 same-cycle write hidden", out_word, 16'h0000);
    do_select(4'd4);
    do_read(1'b0, 16'h0002, "R11 write visible on next read");

    // R9 clear wins over a same-cycle user write
    clr = 1'b1; wr_en = 1'b1; wr_user = 1'b1; wr_page = 7'd0;
    tick();
    clr = 1'b0; wr_en = 1'b0; wr_user = 1'b0;
    do_write(7'd8, 1'b1);
    do_write(7'd48, 1'b1);
    do_write(7'd56, 1'b1);
    do_select(4'd0);
    do_read(1'b0, 16'h0100, "R9 clear beat write to page 0");

    // R4 select and read in one cycle: read uses old pointer, select wins
    sel_en = 1'b1; sel_hb = 4'd6;
    rd_valid = 1'b1; rd_adv = 1'b1;
    tick();
    sel_en = 1'b0; rd_valid = 1'b0; rd_adv = 1'b0;
    chk(out_word === 16'h0001, "R4 read used old pointer", out_word, 16'h0001);
    do_read(1'b0, 16'h0101, "R4 select beat read step");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule